// File: doc/BRIEF.md
# Text Mode Split Plane Address Generator

During text-mode display refresh the 32-bit video memory is treated as two independent 16-bit halves, each with its own address bus. Bus A reaches planes 0 and 1 and fetches the character code and the attribute byte for the current cell. In the same memory cycle, bus B reaches planes 2 and 3 and fetches one glyph byte. That glyph byte belongs to the character code captured on the previous fetch. The font fetch therefore runs one character behind the code fetch.

Bus A follows the refresh address. Its two top bits are forced to zero when the memory is configured as 64K. Bus B is formed from the selected character map, the previously captured code and the font scan line. Each character clock enable captures the code, attribute and glyph bytes into output registers. On the first character of each scan line the glyph register is primed to zero, because the font fetch in that cycle has no valid preceding character on the line. Attribute decoding and pixel shifting take place downstream.

Top module: `txt_split_addr`

## Requirements
- R1: Bits 13:0 of bus A equal bits 13:0 of the refresh address in the same cycle.
- R2: Bits 15:14 of bus A equal bits 15:14 of the refresh address when `mem_64k` is 0, and are 0 when `mem_64k` is 1.
- R3: Bus B is formed as follows: bits 15:14 carry the character-map select, bit 13 is 0, bits 12:5 carry the registered code output `code_q`, and bits 4:0 carry the scan line. The low part is therefore code*32 + scan line.
- R4: On a clock edge with `chr_tick` high, `code_q` loads the plane 0 byte and `attr_q` loads the plane 1 byte.
- R5: On a clock edge with `chr_tick` high and `line_first` low, `glyph_q` loads the plane 2 byte. This byte was fetched with the code held before that edge, so `glyph_q` lags `code_q` by one character.
- R6: On a clock edge with both `chr_tick` and `line_first` high, `glyph_q` becomes 0 while `code_q` and `attr_q` load as in R4.
- R7: On a clock edge with `chr_tick` low, `code_q`, `attr_q` and `glyph_q` keep their values.
- R8: While `rst` is high, `code_q`, `attr_q` and `glyph_q` become 0, so bus B shows only the map select and the scan line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_tick | input | 1 | Character clock enable, one fetch per pulse |
| line_first | input | 1 | Marks the first character of a scan line |
| mem_64k | input | 1 | Memory size: 1 selects 64K, 0 selects 256K |
| refresh_addr | input | 16 | Refresh address from the display counter |
| scan_line | input | 5 | Current font scan line |
| map_sel | input | 2 | Selected character map |
| pl0_data | input | 8 | Byte returned from plane 0 (code) |
| pl1_data | input | 8 | Byte returned from plane 1 (attribute) |
| pl2_data | input | 8 | Byte returned from plane 2 (glyph) |
| addr_a | output | 16 | Address bus for planes 0 and 1 |
| addr_b | output | 16 | Address bus for planes 2 and 3 |
| code_q | output | 8 | Captured character code |
| attr_q | output | 8 | Captured attribute |
| glyph_q | output | 8 | Captured glyph byte, one character behind |

## Verification
The bench builds the block with its default parameters: 16-bit buses, 8-bit codes, 5-bit scan lines and a 2-bit map select. With these values every bus-B field sits at its stated bit position, and the single padding bit at bit 13 can be observed. A hashed memory model in the bench drives the plane bytes back from the two buses. This makes any mix-up between bus A and bus B, or between the current and the previous code, show up in the captured bytes. The random mix of tick gaps, line starts and 64K toggling reaches the hold, prime and masking paths. Directed cases cover the all-ones refresh address and the largest code/scan combination.

// File: rtl/txt_split_pkg.sv
package txt_split_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] code;
        logic [BYTE_W-1:0] attr;
        logic [BYTE_W-1:0] glyph;
    } fetch_t;

    typedef enum logic [1:0] {
        CAP_HOLD  = 2'd0,
        CAP_LOAD  = 2'd1,
        CAP_PRIME = 2'd2
    } cap_op_e;

    function automatic cap_op_e cap_decode(input logic tick, input logic first);
        if (!tick)
            return CAP_HOLD;
        else if (first)
            return CAP_PRIME;
        else
            return CAP_LOAD;
    endfunction

endpackage

// File: rtl/txt_refresh_addr.sv
module txt_refresh_addr #(
    parameter int ADDR_W = 16,
    parameter int HI_W   = 2
) (
    input  logic [ADDR_W-1:0] refresh_addr,
    input  logic              mem_64k,
    output logic [ADDR_W-1:0] addr_a
);
    localparam int LO_W = ADDR_W - HI_W;

    logic [HI_W-1:0] hi_bits;

    always_comb begin
        hi_bits = mem_64k ? '0 : refresh_addr[ADDR_W-1:LO_W];
        addr_a  = {hi_bits, refresh_addr[LO_W-1:0]};
    end
endmodule

// File: rtl/txt_font_addr.sv
module txt_font_addr #(
    parameter int ADDR_W = 16,
    parameter int MAP_W  = 2,
    parameter int CODE_W = 8,
    parameter int SCAN_W = 5
) (
    input  logic [MAP_W-1:0]  map_sel,
    input  logic [CODE_W-1:0] prev_code,
    input  logic [SCAN_W-1:0] scan_line,
    output logic [ADDR_W-1:0] addr_b
);
    localparam int PAD_W = ADDR_W - MAP_W - CODE_W - SCAN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            logic [PAD_W-1:0] pad;
            assign pad    = '0;
            assign addr_b = {map_sel, pad, prev_code, scan_line};
        end else begin : g_nopad
            assign addr_b = {map_sel, prev_code, scan_line};
        end
    endgenerate
endmodule

// File: rtl/txt_fetch_regs.sv
module txt_fetch_regs
    import txt_split_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chr_tick,
    input  logic              line_first,
    input  logic [BYTE_W-1:0] pl0_data,
    input  logic [BYTE_W-1:0] pl1_data,
    input  logic [BYTE_W-1:0] pl2_data,
    output fetch_t            cap_q
);
    cap_op_e op;
    fetch_t  cap_d;

    always_comb begin
        op    = cap_decode(chr_tick, line_first);
        cap_d = cap_q;
        unique case (op)
            CAP_LOAD: begin
                cap_d.code  = pl0_data;
                cap_d.attr  = pl1_data;
                cap_d.glyph = pl2_data;
            end
            CAP_PRIME: begin
                cap_d.code  = pl0_data;
                cap_d.attr  = pl1_data;
                cap_d.glyph = '0;
            end
            default: cap_d = cap_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else
            cap_q <= cap_d;
    end
endmodule

// File: rtl/txt_split_addr.sv
module txt_split_addr
    import txt_split_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MAP_W  = 2,
    parameter int SCAN_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chr_tick,
    input  logic              line_first,
    input  logic              mem_64k,
    input  logic [ADDR_W-1:0] refresh_addr,
    input  logic [SCAN_W-1:0] scan_line,
    input  logic [MAP_W-1:0]  map_sel,
    input  logic [BYTE_W-1:0] pl0_data,
    input  logic [BYTE_W-1:0] pl1_data,
    input  logic [BYTE_W-1:0] pl2_data,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b,
    output logic [BYTE_W-1:0] code_q,
    output logic [BYTE_W-1:0] attr_q,
    output logic [BYTE_W-1:0] glyph_q
);
    fetch_t cap_q;

    txt_refresh_addr #(.ADDR_W(ADDR_W), .HI_W(MAP_W)) u_bus_a (
        .refresh_addr (refresh_addr),
        .mem_64k      (mem_64k),
        .addr_a       (addr_a)
    );

    txt_font_addr #(.ADDR_W(ADDR_W), .MAP_W(MAP_W), .CODE_W(BYTE_W), .SCAN_W(SCAN_W)) u_bus_b (
        .map_sel   (map_sel),
        .prev_code (cap_q.code),
        .scan_line (scan_line),
        .addr_b    (addr_b)
    );

    txt_fetch_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .chr_tick   (chr_tick),
        .line_first (line_first),
        .pl0_data   (pl0_data),
        .pl1_data   (pl1_data),
        .pl2_data   (pl2_data),
        .cap_q      (cap_q)
    );

    assign code_q  = cap_q.code;
    assign attr_q  = cap_q.attr;
    assign glyph_q = cap_q.glyph;
endmodule

// File: rtl/txt_split_addr_chk.sv
module txt_split_addr_chk (
    input logic        clk,
    input logic        rst,
    input logic        chr_tick,
    input logic        line_first,
    input logic        mem_64k,
    input logic [15:0] refresh_addr,
    input logic [4:0]  scan_line,
    input logic [1:0]  map_sel,
    input logic [7:0]  pl0_data,
    input logic [7:0]  pl1_data,
    input logic [7:0]  pl2_data,
    input logic [15:0] addr_a,
    input logic [15:0] addr_b,
    input logic [7:0]  code_q,
    input logic [7:0]  attr_q,
    input logic [7:0]  glyph_q
);
    a_r1_low_pass: assert property (@(posedge clk) disable iff (rst)
        addr_a[13:0] == refresh_addr[13:0]);

    a_r2_mask_64k: assert property (@(posedge clk) disable iff (rst)
        mem_64k |-> addr_a[15:14] == 2'b00);

    a_r3_font_fields: assert property (@(posedge clk) disable iff (rst)
        addr_b[12:5] == code_q && addr_b[15:14] == map_sel && addr_b[4:0] == scan_line);

    a_r4_code_attr_load: assert property (@(posedge clk) disable iff (rst)
        chr_tick |=> code_q == $past(pl0_data) && attr_q == $past(pl1_data));

    a_r5_glyph_load: assert property (@(posedge clk) disable iff (rst)
        (chr_tick && !line_first) |=> glyph_q == $past(pl2_data));

    a_r6_glyph_prime: assert property (@(posedge clk) disable iff (rst)
        (chr_tick && line_first) |=> glyph_q == 8'h00);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !chr_tick |=> $stable(code_q) && $stable(attr_q) && $stable(glyph_q));
endmodule

bind txt_split_addr txt_split_addr_chk u_chk (.*);

// File: tb/txt_split_addr_tb.sv
module txt_split_addr_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        chr_tick, line_first, mem_64k;
    logic [15:0] refresh_addr;
    logic [4:0]  scan_line;
    logic [1:0]  map_sel;
    logic [7:0]  pl0_data, pl1_data, pl2_data;
    logic [15:0] addr_a, addr_b;
    logic [7:0]  code_q, attr_q, glyph_q;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] m_code, m_attr, m_glyph;

    always #(CLK_PERIOD/2) clk = ~clk;

    txt_split_addr dut_i (.*);

    function automatic logic [7:0] mem_p0(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] mem_p1(input logic [15:0] a);
        return (a[7:0] + 8'd3 * a[15:8]) ^ 8'h33;
    endfunction
    function automatic logic [7:0] mem_p2(input logic [15:0] a);
        return {a[2:0], a[7:3]} ^ a[15:8] ^ 8'hC6;
    endfunction

    always_comb begin
        pl0_data = mem_p0(addr_a);
        pl1_data = mem_p1(addr_a);
        pl2_data = mem_p2(addr_b);
    end

    function automatic logic [15:0] exp_a(input logic [15:0] r, input logic m64);
        return m64 ? {2'b00, r[13:0]} : r;
    endfunction
    function automatic logic [15:0] exp_b(input logic [1:0] m, input logic [7:0] c, input logic [4:0] s);
        return {m, 1'b0, c, s};
    endfunction

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check, then advance the model.
    task automatic step(input logic t, input logic f, input logic m64,
                        input logic [15:0] r, input logic [4:0] s, input logic [1:0] m);
        logic [15:0] ea, eb;
        chr_tick = t; line_first = f; mem_64k = m64;
        refresh_addr = r; scan_line = s; map_sel = m;
        #1;
        ea = exp_a(r, m64);
        eb = exp_b(m, m_code, s);
        chk16("R1 bus A low bits", {2'b00, addr_a[13:0]}, {2'b00, ea[13:0]});
        chk16("R2 bus A high bits", {14'd0, addr_a[15:14]}, {14'd0, ea[15:14]});
        chk16("R3 bus B address", addr_b, eb);
        if (t) begin
            m_glyph = f ? 8'h00 : mem_p2(eb);
            m_code  = mem_p0(ea);
            m_attr  = mem_p1(ea);
        end
        @(negedge clk);
        #1;
        chk8(t ? "R4 code capture" : "R7 code hold", code_q, m_code);
        chk8(t ? "R4 attr capture" : "R7 attr hold", attr_q, m_attr);
        chk8(t ? (f ? "R6 glyph prime" : "R5 glyph capture") : "R7 glyph hold", glyph_q, m_glyph);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] ra;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; chr_tick = 1'b1; line_first = 1'b0; mem_64k = 1'b0;
        refresh_addr = 16'hABCD; scan_line = 5'd9; map_sel = 2'd2;
        repeat (3) @(negedge clk);
        #1;
        chk8("R8 reset code", code_q, 8'h00);
        chk8("R8 reset attr", attr_q, 8'h00);
        chk8("R8 reset glyph", glyph_q, 8'h00);
        chk16("R8 reset bus B", addr_b, 16'h8009);
        m_code = 8'h00; m_attr = 8'h00; m_glyph = 8'h00;
        rst = 1'b0;

        // Directed: masking of the top bits at all-ones refresh address
        step(1'b1, 1'b1, 1'b0, 16'hFFFF, 5'd0, 2'd0);
        step(1'b1, 1'b0, 1'b1, 16'hFFFF, 5'd31, 2'd3);
        step(1'b1, 1'b0, 1'b1, 16'hC001, 5'd31, 2'd3);
        // Directed: hold with inputs changing
        step(1'b0, 1'b1, 1'b0, 16'h1234, 5'd7, 2'd1);
        step(1'b0, 1'b0, 1'b0, 16'h4321, 5'd8, 2'd2);
        // Directed: a short line with a prime on its first character
        ra = 16'h7FFE;
        for (int i = 0; i < 6; i++) begin
            step(1'b1, i == 0, 1'b0, ra, 5'd31, 2'd3);
            ra = ra + 16'd1;
        end

        // Constrained random lines
        ra = 16'($urandom);
        for (int i = 0; i < 3000; i++) begin
            logic t, f, m64;
            logic [4:0] s;
            logic [1:0] m;
            t   = ($urandom % 4) != 0;
            f   = t && (($urandom % 8) == 0);
            m64 = ($urandom % 3) == 0;
            s   = 5'($urandom);
            m   = 2'($urandom);
            if (f) ra = 16'($urandom);
            step(t, f, m64, ra, s, m);
            if (t) ra = ra + 16'd1;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule